// File: doc/BRIEF.md
# Latched Two-Port Register File

A 32-word by 32-bit register file with two read ports, A and B, and one write port that always targets the word selected by the B address. A phase input divides each cycle into two halves. While the phase is high, both read outputs follow the selected words. While it is low, both outputs freeze on the last values they passed, and a pending write updates the array. A read of a word, an outside operation on it, and the write of the result back into the same word therefore all fit inside one phase cycle, and the outputs do not change while the write happens.

The write data passes through a three-way selector before it reaches the array. The selector passes the data unchanged, moves it one bit toward the MSB, or moves it one bit toward the LSB. A serial input supplies the bit that enters at the vacated end. The logic that decodes which move to use sits outside this block. The array contents are not reset. Only the two held output values are cleared by reset.

The whole block runs on one system clock. The phase input is sampled at each rising clock edge and acts as a phase enable.

Top module: `latched_rf`

## Requirements
- R1: The array holds WORDS words of WIDTH bits (defaults 32 and 32). The 5-bit `a_addr` and `b_addr` select words for the A and B outputs independently and at the same time.
- R2: When `a_addr` equals `b_addr`, `a_out` and `b_out` present the same word.
- R3: A write occurs at a rising `clk` edge where `phase` is low and `wr_en` is high. It stores into the word at `b_addr`, and the stored word is visible on the next high phase.
- R4: While `phase` is high, each output shows the current content of the word its address selects.
- R5: While `phase` is low, each output holds the value it showed at the last rising `clk` edge with `phase` high. Changing `a_addr` or `b_addr` during the low phase has no effect on the outputs.
- R6: Nothing is written while `phase` is high, even with `wr_en` high, and nothing is written while `wr_en` is low.
- R7: `shift_sel` = 2'b01 stores `{wr_data[30:0], ser_lo_in}`, which moves the data up one bit and puts the serial bit in bit 0.
- R8: `shift_sel` = 2'b10 stores `{ser_hi_in, wr_data[31:1]}`, which moves the data down one bit and puts the serial bit in bit 31. Codes 2'b00 and 2'b11 store `wr_data` unchanged.
- R9: A write during the low phase, including a write to the word currently held, does not change `a_out` or `b_out` until the phase returns high.
- R10: An active-low `rst_n` clears both held values to zero. The array contents survive a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low reset of the held output values |
| phase | input | 1 | High: outputs transparent. Low: outputs held and write allowed |
| a_addr | input | 5 | Word select for the A output |
| b_addr | input | 5 | Word select for the B output and the write target |
| wr_en | input | 1 | Write request, acted on only in the low phase |
| shift_sel | input | 2 | Write data move: 00/11 none, 01 up, 10 down |
| wr_data | input | 32 | Data to be written |
| ser_lo_in | input | 1 | Bit entering bit 0 on an up move |
| ser_hi_in | input | 1 | Bit entering bit 31 on a down move |
| a_out | output | 32 | A port word |
| b_out | output | 32 | B port word |

## Verification
The bench builds the block with its default parameters, 32 words of 32 bits. With those values, addresses near both ends of the 5-bit range can be used, and the serial bits can be checked entering at the real bit 0 and bit 31. A vector table drives sequences of low-phase and high-phase cycles covering several cases:
- back-to-back writes in every move mode;
- address changes during the hold;
- a write during the high phase, which must be ignored;
- a read-modify-write of one word.

Directed steps then check that reset clears the held outputs and leaves the array contents in place.

// File: rtl/rf_pkg.sv
package rf_pkg;

    // Move applied to the write data before it is stored
    typedef enum logic [1:0] {
        MV_NONE  = 2'b00,
        MV_UP    = 2'b01,
        MV_DOWN  = 2'b10,
        MV_NONE2 = 2'b11
    } move_e;

    localparam int unsigned NUM_RD = 2;
    localparam int unsigned PORT_A = 0;
    localparam int unsigned PORT_B = 1;

endpackage

// File: rtl/rf_wdata_sel.sv
module rf_wdata_sel
    import rf_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [1:0]       move,
    input  logic [WIDTH-1:0] din,
    input  logic             lo_bit,
    input  logic             hi_bit,
    output logic [WIDTH-1:0] dout
);

    // Only the three move variants are possible; the unused code falls back to no move
    always_comb begin
        unique case (move)
            MV_UP:   dout = {din[WIDTH-2:0], lo_bit};
            MV_DOWN: dout = {hi_bit, din[WIDTH-1:1]};
            default: dout = din;
        endcase
    end

endmodule

// File: rtl/rf_array.sv
module rf_array
    import rf_pkg::*;
#(
    parameter int unsigned WORDS = 32,
    parameter int unsigned WIDTH = 32,
    localparam int unsigned AW = $clog2(WORDS)
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [AW-1:0]                 waddr,
    input  logic [WIDTH-1:0]              wdata,
    input  logic [NUM_RD-1:0][AW-1:0]     raddr,
    output logic [NUM_RD-1:0][WIDTH-1:0]  rdata
);

    // Storage has no reset by design
    logic [WIDTH-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rdata[p] = mem_q[raddr[p]];
    end

endmodule

// File: rtl/rf_hold_port.sv
module rf_hold_port #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase,
    input  logic [WIDTH-1:0] live,
    output logic [WIDTH-1:0] seen
);

    typedef struct packed {
        logic [WIDTH-1:0] val;
    } hold_t;

    hold_t hold_d, hold_q;

    // Transparent while phase is high, frozen while low
    always_comb begin
        hold_d = hold_q;
        if (phase) begin
            hold_d.val = live;
        end
        seen = phase ? live : hold_q.val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

endmodule

// File: rtl/latched_rf.sv
module latched_rf
    import rf_pkg::*;
#(
    parameter int unsigned WORDS = 32,
    parameter int unsigned WIDTH = 32,
    localparam int unsigned AW = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase,
    input  logic [AW-1:0]    a_addr,
    input  logic [AW-1:0]    b_addr,
    input  logic             wr_en,
    input  logic [1:0]       shift_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             ser_lo_in,
    input  logic             ser_hi_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] b_out
);

    logic [WIDTH-1:0]             moved;
    logic                         arr_we;
    logic [NUM_RD-1:0][AW-1:0]    rd_addr;
    logic [NUM_RD-1:0][WIDTH-1:0] rd_live;
    logic [NUM_RD-1:0][WIDTH-1:0] rd_seen;

    // Writes only happen in the low phase
    assign arr_we = wr_en & ~phase;
    assign rd_addr[PORT_A] = a_addr;
    assign rd_addr[PORT_B] = b_addr;

    rf_wdata_sel #(.WIDTH(WIDTH)) u_sel (
        .move   (shift_sel),
        .din    (wr_data),
        .lo_bit (ser_lo_in),
        .hi_bit (ser_hi_in),
        .dout   (moved)
    );

    rf_array #(.WORDS(WORDS), .WIDTH(WIDTH)) u_arr (
        .clk   (clk),
        .we    (arr_we),
        .waddr (b_addr),
        .wdata (moved),
        .raddr (rd_addr),
        .rdata (rd_live)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_hold
        rf_hold_port #(.WIDTH(WIDTH)) u_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .phase (phase),
            .live  (rd_live[p]),
            .seen  (rd_seen[p])
        );
    end

    assign a_out = rd_seen[PORT_A];
    assign b_out = rd_seen[PORT_B];

endmodule

// File: rtl/rf_checks.sv
module rf_checks #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned AW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             phase,
    input logic [AW-1:0]    a_addr,
    input logic [AW-1:0]    b_addr,
    input logic             wr_en,
    input logic [1:0]       shift_sel,
    input logic [WIDTH-1:0] wr_data,
    input logic             ser_lo_in,
    input logic             ser_hi_in,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] b_out
);

    p_same_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && a_addr == b_addr) |-> (a_out == b_out));

    p_write_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase && wr_en && (shift_sel == 2'b00 || shift_sel == 2'b11))
        |=> (!phase || a_addr != $past(b_addr) || a_out == $past(wr_data)));

    p_hold_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |=> (phase || $stable(a_out)));

    p_hold_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |=> (phase || $stable(b_out)));

    p_shift_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase && wr_en && shift_sel == 2'b01)
        |=> (!phase || a_addr != $past(b_addr)
             || a_out == $past({wr_data[WIDTH-2:0], ser_lo_in})));

    p_shift_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase && wr_en && shift_sel == 2'b10)
        |=> (!phase || a_addr != $past(b_addr)
             || a_out == $past({ser_hi_in, wr_data[WIDTH-1:1]})));

endmodule

bind latched_rf rf_checks #(.WIDTH(WIDTH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .a_addr    (a_addr),
    .b_addr    (b_addr),
    .wr_en     (wr_en),
    .shift_sel (shift_sel),
    .wr_data   (wr_data),
    .ser_lo_in (ser_lo_in),
    .ser_hi_in (ser_hi_in),
    .a_out     (a_out),
    .b_out     (b_out)
);

// File: tb/sim_latched_rf.sv
`timescale 1ns/1ps
module sim_latched_rf;

    localparam int NV = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase = 1'b0;
    logic [4:0]  a_addr = '0, b_addr = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  shift_sel = 2'b00;
    logic [31:0] wr_data = '0;
    logic        ser_lo_in = 1'b0, ser_hi_in = 1'b0;
    logic [31:0] a_out, b_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    latched_rf u0 (
        .clk(clk), .rst_n(rst_n), .phase(phase), .a_addr(a_addr), .b_addr(b_addr),
        .wr_en(wr_en), .shift_sel(shift_sel), .wr_data(wr_data),
        .ser_lo_in(ser_lo_in), .ser_hi_in(ser_hi_in), .a_out(a_out), .b_out(b_out)
    );

    // Vector layout: phase, a, b, we, move, data, lo, hi, exp_a, exp_b
    function automatic logic [111:0] v(logic p, logic [4:0] a, logic [4:0] b, logic we,
                                       logic [1:0] sh, logic [31:0] d, logic lo, logic hi,
                                       logic [31:0] ea, logic [31:0] eb);
        return {p, a, b, we, sh, d, lo, hi, ea, eb};
    endfunction

    localparam logic [111:0] VEC [NV] = '{
        v(0, 0, 3, 1, 2'b00, 32'h12345678, 0, 0, 32'h0, 32'h0),               // R10 reset hold, R3
        v(0, 0, 7, 1, 2'b01, 32'h80000001, 1, 0, 32'h0, 32'h0),               // R7
        v(0, 0, 9, 1, 2'b10, 32'h00000003, 0, 1, 32'h0, 32'h0),               // R8
        v(0, 0, 10, 1, 2'b01, 32'h40000000, 0, 0, 32'h0, 32'h0),              // R7
        v(0, 0, 11, 1, 2'b10, 32'h80000000, 0, 0, 32'h0, 32'h0),              // R8
        v(1, 3, 7, 0, 2'b00, 32'h0, 0, 0, 32'h12345678, 32'h00000003),        // R1 R4
        v(0, 9, 7, 0, 2'b00, 32'h0, 0, 0, 32'h12345678, 32'h00000003),        // R5
        v(0, 9, 7, 1, 2'b00, 32'hDEADBEEF, 0, 0, 32'h12345678, 32'h00000003), // R9
        v(1, 7, 7, 0, 2'b00, 32'h0, 0, 0, 32'hDEADBEEF, 32'hDEADBEEF),        // R2 R3
        v(1, 9, 10, 0, 2'b00, 32'h0, 0, 0, 32'h80000001, 32'h80000000),       // R7 R8
        v(1, 11, 3, 1, 2'b00, 32'h0, 0, 0, 32'h40000000, 32'h12345678),       // R6
        v(1, 3, 3, 0, 2'b00, 32'h0, 0, 0, 32'h12345678, 32'h12345678),        // R6
        v(0, 0, 11, 0, 2'b00, 32'hFFFFFFFF, 0, 0, 32'h12345678, 32'h12345678),// R5 R6
        v(1, 11, 3, 0, 2'b00, 32'h0, 0, 0, 32'h40000000, 32'h12345678),       // R6
        v(0, 12, 12, 1, 2'b11, 32'h0000F00F, 1, 1, 32'h40000000, 32'h12345678),// R8 code 11
        v(1, 12, 12, 0, 2'b00, 32'h0, 0, 0, 32'h0000F00F, 32'h0000F00F),      // R8
        v(1, 12, 12, 0, 2'b00, 32'h0, 0, 0, 32'h0000F00F, 32'h0000F00F),      // R9 read
        v(0, 12, 12, 1, 2'b00, 32'h0000F010, 0, 0, 32'h0000F00F, 32'h0000F00F),// R9 modify-write
        v(1, 12, 12, 0, 2'b00, 32'h0, 0, 0, 32'h0000F010, 32'h0000F010)       // R9 result
    };

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R10", "a_out in reset", a_out, 32'h0);
        check("R10", "b_out in reset", b_out, 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [111:0] e;
            e = VEC[i];
            phase     = e[111];
            a_addr    = e[110:106];
            b_addr    = e[105:101];
            wr_en     = e[100];
            shift_sel = e[99:98];
            wr_data   = e[97:66];
            ser_lo_in = e[65];
            ser_hi_in = e[64];
            @(posedge clk);
            #2;
            check("R1-vector", $sformatf("a_out vec %0d", i), a_out, e[63:32]);
            check("R1-vector", $sformatf("b_out vec %0d", i), b_out, e[31:0]);
            @(negedge clk);
        end
        // R10: reset clears the held outputs but not the array
        wr_en = 1'b0;
        phase = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R10", "held a after reset", a_out, 32'h0);
        check("R10", "held b after reset", b_out, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        phase = 1'b1;
        a_addr = 5'd12;
        b_addr = 5'd3;
        @(posedge clk);
        #2;
        check("R10", "array kept a", a_out, 32'h0000F010);
        check("R10", "array kept b", b_out, 32'h12345678);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule